// File: doc/BRIEF.md
# Four-Word Registered-Output Queue

This block is a small first-in-first-out buffer for 64-bit words, four entries deep. A producer raises a write strobe alongside a data word to enqueue it. A consumer reads the oldest word, which is always on the head output, and raises a pop request to discard it.

Every output comes straight from a flop, including the head word, the empty, full and valid flags, and the fault flag. The outputs therefore move only at a rising clock edge. A write into a full queue is dropped without notice. A pop of an empty queue does nothing. While the queue is empty, the head output reads as zero.

The fault flag watches the internal bookkeeping. It rises if the occupancy counter goes past the depth, or if the counter no longer matches the distance between the write and read pointers. Reset is synchronous and active high, and it empties the queue.

Top module: `quad_word_fifo`

## Requirements
- R1: The queue holds up to DEPTH=4 words of WIDTH=64 bits. One word is stored on every rising edge at which `push_valid` is high and `is_full` is low.
- R2: `head_data` always shows the oldest stored word. A pop taken at an edge removes that word, so words leave in the order they arrived.
- R3: A push while `is_full` is high, without a pop, is discarded. The stored words and `head_data` stay unchanged.
- R4: A pop request while `is_empty` is high has no effect.
- R5: While the queue holds no word, `is_empty` is 1 and `head_data` is all zeros.
- R6: `is_full` is 1 exactly when four words are stored.
- R7: With both push and pop requested on a queue that is neither empty nor full, both happen: the head advances, the new word is appended, and occupancy stays the same.
- R8: With both push and pop requested on a full queue, the head is popped and the incoming word is dropped, because fullness is judged before the pop.
- R9: `head_valid` is always the inverse of `is_empty`.
- R10: `fault` is registered. It goes high if the occupancy count exceeds DEPTH or differs from the write-pointer minus read-pointer distance. It stays low in correct operation.
- R11: `rst` is synchronous and active high. One edge with it high leaves the queue empty, with `head_data` zero, `is_full` low and `fault` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Write strobe |
| push_data | input | 64 | Word to enqueue |
| pop_req | input | 1 | Discard the head word |
| head_data | output | 64 | Oldest stored word, zero when empty |
| head_valid | output | 1 | Head word is meaningful |
| is_empty | output | 1 | No word stored |
| is_full | output | 1 | Four words stored |
| fault | output | 1 | Internal bookkeeping inconsistent |

## Verification
Push and pop can arrive in the same cycle, and the outcome depends on occupancy. When neither full nor empty, both requests take effect. When full, only the pop survives. When empty, only the push survives, and the new word must appear on the head the very next edge.

The bench provokes all three cases with directed sequences and then with a long run of random strobes. A queue-based reference model predicts every output for the following edge. Each output is compared with that prediction at the falling edge of every cycle.

// File: rtl/quad_word_fifo.sv
module quad_word_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_valid,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop_req,
  output logic [WIDTH-1:0] head_data,
  output logic             head_valid,
  output logic             is_empty,
  output logic             is_full,
  output logic             fault
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [CW-1:0] wr_q, rd_q, cnt_q;
  logic [CW-1:0] wr_d, rd_d, cnt_d;
  logic push_ok, pop_ok;
  logic [WIDTH-1:0] head_d;

  assign push_ok = push_valid && !is_full;
  assign pop_ok  = pop_req && !is_empty;
  assign wr_d    = wr_q + CW'(push_ok);
  assign rd_d    = rd_q + CW'(pop_ok);
  assign cnt_d   = cnt_q + CW'(push_ok) - CW'(pop_ok);

  always_comb begin
    if (cnt_d == '0)
      head_d = '0;
    else if (push_ok && cnt_q == CW'(pop_ok))
      head_d = push_data;
    else
      head_d = mem[rd_d[PW-1:0]];
  end

  always_ff @(posedge clk)
    if (push_ok) mem[wr_q[PW-1:0]] <= push_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q       <= '0;
      rd_q       <= '0;
      cnt_q      <= '0;
      head_data  <= '0;
      head_valid <= 1'b0;
      is_empty   <= 1'b1;
      is_full    <= 1'b0;
      fault      <= 1'b0;
    end else begin
      wr_q       <= wr_d;
      rd_q       <= rd_d;
      cnt_q      <= cnt_d;
      head_data  <= head_d;
      head_valid <= cnt_d != '0;
      is_empty   <= cnt_d == '0;
      is_full    <= cnt_d == CW'(DEPTH);
      fault      <= (cnt_d > CW'(DEPTH)) || (cnt_d != CW'(wr_d - rd_d));
    end
  end

  p_drop_when_full_r3: assert property (@(posedge clk) disable iff (rst)
    is_full && push_valid && !pop_req |=> is_full && $stable(head_data));
  p_pop_empty_r4: assert property (@(posedge clk) disable iff (rst)
    is_empty && !push_valid |=> is_empty);
  p_empty_zero_r5: assert property (@(posedge clk) disable iff (rst)
    is_empty |-> head_data == '0);
  p_full_needs_push_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(is_full) |-> $past(push_valid));
  p_full_pop_r8: assert property (@(posedge clk) disable iff (rst)
    is_full && push_valid && pop_req |=> !is_full && !is_empty);
  p_valid_inv_r9: assert property (@(posedge clk) disable iff (rst)
    head_valid == !is_empty);
  p_fault_low_r10: assert property (@(posedge clk) disable iff (rst)
    !fault);
  p_after_reset_r11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> is_empty && !is_full && !fault);
endmodule

// File: tb/quad_word_fifo_test.sv
module quad_word_fifo_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_valid = 1'b0;
  logic [63:0] push_data = '0;
  logic        pop_req = 1'b0;
  logic [63:0] head_data;
  logic        head_valid, is_empty, is_full, fault;

  int tests = 0;
  int fails = 0;
  bit primed = 0;
  logic [63:0] model [$];

  always #5 clk = ~clk;

  quad_word_fifo uut (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
    .pop_req(pop_req), .head_data(head_data), .head_valid(head_valid),
    .is_empty(is_empty), .is_full(is_full), .fault(fault));

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic compare(string tag);
    logic [63:0] eh;
    eh = (model.size() != 0) ? model[0] : 64'h0;
    chk({tag, " head (R2)"}, head_data, eh);
    chk("R5 empty flag", {63'h0, is_empty}, {63'h0, model.size() == 0});
    chk("R6 full flag", {63'h0, is_full}, {63'h0, model.size() == 4});
    chk("R9 valid flag", {63'h0, head_valid}, {63'h0, model.size() != 0});
    chk("R10 fault", {63'h0, fault}, 64'h0);
  endtask

  task automatic step(bit r, bit p, logic [63:0] d, bit o, string tag);
    bit full_now, empty_now;
    @(negedge clk);
    if (primed) compare(tag);
    rst = r; push_valid = p; push_data = d; pop_req = o;
    full_now = model.size() == 4;
    empty_now = model.size() == 0;
    if (r) model.delete();
    else begin
      if (o && !empty_now) void'(model.pop_front());
      if (p && !full_now) model.push_back(d);
    end
    primed = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    step(1, 0, 0, 0, "R11");
    step(1, 0, 0, 0, "R11");
    for (int i = 0; i < 4; i++) step(0, 1, 64'hA000_0000_0000_0000 + i, 0, "R1");
    step(0, 1, 64'hDEAD_BEEF_0000_0001, 0, "R3");
    step(0, 1, 64'hDEAD_BEEF_0000_0002, 0, "R3");
    step(0, 1, 64'hBAD0_0000_0000_0003, 1, "R8");
    step(0, 1, 64'hB000_0000_0000_0004, 0, "R1");
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1, "R2");
    step(0, 0, 0, 1, "R4");
    step(0, 0, 0, 1, "R4");
    step(0, 1, 64'hC000_0000_0000_0000, 1, "R4");
    for (int i = 1; i < 5; i++) step(0, 1, 64'hC000_0000_0000_0000 + i, 1, "R7");
    step(0, 1, 64'hD000_0000_0000_0001, 0, "R1");
    step(0, 1, 64'hD000_0000_0000_0002, 1, "R7");
    step(1, 1, 64'hE000_0000_0000_0000, 0, "R11");
    step(0, 0, 0, 0, "R11");
    step(0, 0, 0, 1, "R5");
    for (int i = 0; i < 600; i++)
      step(($urandom % 97) == 0, ($urandom % 3) != 0, {$urandom, $urandom},
           ($urandom % 2) == 0, "random");
    @(negedge clk);
    compare("final");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule